// File: doc/BRIEF.md
# Audio codec serial command sequencer

This block drives the three-wire control port of a stereo audio converter: a serial clock, a data line and two active-low selects, one for the playback codec and one for the input-level codec. Words leave MSB first, one bit per serial clock period. The data line changes on the falling edge of the serial clock, and the converter samples it on the rising edge. Each serial clock phase lasts `DIV` system clocks. A select stays low for the whole word.

After reset the block brings the converter up without help. It holds the converter reset line on its own for `WAIT_CYCLES` clocks. It then raises mute and enable next to reset and waits another `WAIT_CYCLES` clocks. Finally it plays a fixed power-up script. After that a host issues requests through a valid/ready port. A request can be a playback level for one channel, a packed capture-level word, or a sample-rate change. A rate change wraps an optional speed-mode command between a mute and an unmute. The block keeps the current speed mode, so it sends the speed command only when the mode actually changes.

Top module: `codec_cmd_seq`

## Requirements
- R1: While `rst_n` is low, both selects and `ser_clk` are high, `busy` and `req_ready` are low, `conv_reset` is high, and `conv_mute` and `conv_enable` are low.
- R2: After reset release, `conv_reset` is the only control line high through the `WAIT_CYCLES`-th clock. `conv_mute` and `conv_enable` rise at that clock. The first select falls `WAIT_CYCLES`+1 clocks later, and no select falls while `conv_enable` is low.
- R3: The power-up script sends, on the playback select, the 16-bit words 0xA007, 0xA240, 0xA30D and 0xA103 in that order.
- R4: Every word is sent MSB first. Each serial clock low phase and each high phase lasts `DIV` clocks. `ser_data` changes only together with a falling `ser_clk` and holds while `ser_clk` is high.
- R5: A request with `req_kind`=0 (playback level) sends one 16-bit word on the playback select: 0xA600+`req_level` when `req_chan`=0, or 0xA700+`req_level` when `req_chan`=1.
- R6: A playback request with `req_chan` above 1, or any request with `req_kind`=3, is accepted and sends nothing.
- R7: A request with `req_kind`=1 (capture levels) sends one 32-bit word on the capture select. Bits 31:24 and 23:16 both hold `req_mic`, bits 15:8 hold `req_line_r` and bits 7:0 hold `req_line_l`.
- R8: A request with `req_kind`=2 (rate change) starts with 0xA38D (mute) and ends with 0xA30D (unmute), both on the playback select.
- R9: Between the mute and the unmute of a rate change, the block sends 0xA240 if `req_rate` < `SPLIT_HZ` and 0xA24D otherwise, but only if that speed mode differs from the stored one. The stored mode is low speed after the power-up script.
- R10: `req_ready` is low from the accepting clock until the accepted script finishes. A request that arrives meanwhile is held and carried out afterwards, never dropped.
- R11: `busy` is high whenever a select is low. It stays high across all words of one script and falls once per script.
- R12: At most one select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_kind | input | 2 | 0 playback level, 1 capture levels, 2 rate change, 3 none |
| req_chan | input | 2 | Playback channel: 0 left, 1 right |
| req_level | input | 8 | Playback level code |
| req_line_l | input | 8 | Left line capture level |
| req_line_r | input | 8 | Right line capture level |
| req_mic | input | 8 | Mic capture level |
| req_rate | input | RATE_W | New sample rate in Hz |
| busy | output | 1 | Script in progress on the serial port |
| conv_reset | output | 1 | Converter reset line |
| conv_mute | output | 1 | Converter mute line |
| conv_enable | output | 1 | Converter codec-enable line |
| ser_clk | output | 1 | Serial bit clock, idles high |
| ser_data | output | 1 | Serial data |
| sel_play_n | output | 1 | Playback codec select, active low |
| sel_cap_n | output | 1 | Input-level codec select, active low |

## Verification
The hardest case to reach is a rate change that both alters and keeps the stored speed mode. That state lives only inside the block, so it can be driven only by a chosen order of rates. The bench walks 48000 (mode unchanged after power-up), 96000 (switch to high), exactly 55000 (boundary, still high) and 54999 (back to low), and checks the number of words after each step. Holding a second request valid while a first word is still shifting exercises the hold-off path.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  localparam int LIST_DEPTH = 4;
  localparam int LIST_IW    = $clog2(LIST_DEPTH);
  localparam int LIST_LW    = $clog2(LIST_DEPTH + 1);

  typedef enum logic [1:0] {
    REQ_PLAY = 2'd0,
    REQ_CAPT = 2'd1,
    REQ_RATE = 2'd2,
    REQ_NONE = 2'd3
  } req_kind_e;

  localparam logic [15:0] OP_POWER    = 16'hA007;
  localparam logic [15:0] OP_SPEED_LO = 16'hA240;
  localparam logic [15:0] OP_SPEED_HI = 16'hA24D;
  localparam logic [15:0] OP_MUTE     = 16'hA38D;
  localparam logic [15:0] OP_UNMUTE   = 16'hA30D;
  localparam logic [15:0] OP_RUN      = 16'hA103;
  localparam logic [15:0] OP_LVL_LEFT = 16'hA600;
  localparam logic [15:0] OP_LVL_RGHT = 16'hA700;

  // one serial transfer: word left-aligned, wide selects 32 bits on capture codec
  typedef struct packed {
    logic [31:0] word;
    logic        wide;
  } xfer_t;

  typedef xfer_t [LIST_DEPTH-1:0] xfer_list_t;

  function automatic xfer_t mk_short(input logic [15:0] op);
    xfer_t x;
    x.word = {op, 16'h0000};
    x.wide = 1'b0;
    return x;
  endfunction

  function automatic xfer_t mk_wide(input logic [31:0] w);
    xfer_t x;
    x.word = w;
    x.wide = 1'b1;
    return x;
  endfunction

endpackage

// File: rtl/codec_shift_engine.sv
module codec_shift_engine
  import codec_seq_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  xfer_t       xfer_i,
  output logic        sclk_o,
  output logic        sdata_o,
  output logic        sel_play_n_o,
  output logic        sel_cap_n_o,
  output logic        done_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH, E_GAP} eng_st_e;

  eng_st_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [4:0]  bits_q, bits_d;
  logic [31:0] sh_q, sh_d;
  logic        sclk_q, sclk_d;
  logic        sdata_q, sdata_d;
  logic        selp_q, selp_d;
  logic        selc_q, selc_d;
  logic        done_q, done_d;
  logic        half_end;

  assign half_end = (cnt_q == CW'(DIV - 1));

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    bits_d  = bits_q;
    sh_d    = sh_q;
    sclk_d  = sclk_q;
    sdata_d = sdata_q;
    selp_d  = selp_q;
    selc_d  = selc_q;
    done_d  = 1'b0;
    case (st_q)
      E_IDLE: begin
        if (start_i) begin
          st_d    = E_LOW;
          cnt_d   = '0;
          sclk_d  = 1'b0;
          sdata_d = xfer_i.word[31];
          sh_d    = {xfer_i.word[30:0], 1'b0};
          bits_d  = xfer_i.wide ? 5'd31 : 5'd15;
          selp_d  = xfer_i.wide;
          selc_d  = ~xfer_i.wide;
        end
      end
      E_LOW: begin
        if (half_end) begin
          st_d   = E_HIGH;
          cnt_d  = '0;
          sclk_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      E_HIGH: begin
        if (half_end) begin
          cnt_d = '0;
          if (bits_q == 5'd0) begin
            selp_d = 1'b1;
            selc_d = 1'b1;
            st_d   = E_GAP;
          end else begin
            sclk_d  = 1'b0;
            sdata_d = sh_q[31];
            sh_d    = {sh_q[30:0], 1'b0};
            bits_d  = bits_q - 1'b1;
            st_d    = E_LOW;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      E_GAP: begin
        if (half_end) begin
          cnt_d  = '0;
          done_d = 1'b1;
          st_d   = E_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= E_IDLE;
      cnt_q   <= '0;
      bits_q  <= '0;
      sh_q    <= '0;
      sclk_q  <= 1'b1;
      sdata_q <= 1'b0;
      selp_q  <= 1'b1;
      selc_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      bits_q  <= bits_d;
      sh_q    <= sh_d;
      sclk_q  <= sclk_d;
      sdata_q <= sdata_d;
      selp_q  <= selp_d;
      selc_q  <= selc_d;
      done_q  <= done_d;
    end
  end

  assign sclk_o       = sclk_q;
  assign sdata_o      = sdata_q;
  assign sel_play_n_o = selp_q;
  assign sel_cap_n_o  = selc_q;
  assign done_o       = done_q;

  // R12: the two codecs are never addressed together
  p_one_select_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~selp_q, ~selc_q}));

  // R4: data holds for the whole high phase of the serial clock
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(sdata_q));

  // R4: data only moves when the serial clock falls
  p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_q) |-> $fell(sclk_q));

endmodule

// File: rtl/codec_req_pack.sv
module codec_req_pack
  import codec_seq_pkg::*;
#(
  parameter int RATE_W   = 18,
  parameter int SPLIT_HZ = 55000
) (
  input  logic [1:0]        kind_i,
  input  logic [1:0]        chan_i,
  input  logic [7:0]        level_i,
  input  logic [7:0]        line_l_i,
  input  logic [7:0]        line_r_i,
  input  logic [7:0]        mic_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              mode_i,
  output xfer_list_t        list_o,
  output logic [LIST_LW-1:0] len_o,
  output logic              mode_o
);

  logic hi_speed;
  logic speed_moves;

  assign hi_speed    = (rate_i >= RATE_W'(SPLIT_HZ));
  assign speed_moves = (hi_speed != mode_i);

  always_comb begin
    for (int k = 0; k < LIST_DEPTH; k++) begin
      list_o[k] = '0;
    end
    len_o  = '0;
    mode_o = mode_i;
    case (kind_i)
      REQ_PLAY: begin
        if (chan_i == 2'd0) begin
          list_o[0] = mk_short(OP_LVL_LEFT + {8'h00, level_i});
          len_o     = LIST_LW'(1);
        end else if (chan_i == 2'd1) begin
          list_o[0] = mk_short(OP_LVL_RGHT + {8'h00, level_i});
          len_o     = LIST_LW'(1);
        end
      end
      REQ_CAPT: begin
        list_o[0] = mk_wide({mic_i, mic_i, line_r_i, line_l_i});
        len_o     = LIST_LW'(1);
      end
      REQ_RATE: begin
        list_o[0] = mk_short(OP_MUTE);
        mode_o    = hi_speed;
        if (speed_moves) begin
          list_o[1] = mk_short(hi_speed ? OP_SPEED_HI : OP_SPEED_LO);
          list_o[2] = mk_short(OP_UNMUTE);
          len_o     = LIST_LW'(3);
        end else begin
          list_o[1] = mk_short(OP_UNMUTE);
          len_o     = LIST_LW'(2);
        end
      end
      default: len_o = '0;
    endcase
  end

endmodule

// File: rtl/codec_seq_ctrl.sv
module codec_seq_ctrl
  import codec_seq_pkg::*;
#(
  parameter int WAIT_CYCLES = 625000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  xfer_list_t         pk_list_i,
  input  logic [LIST_LW-1:0] pk_len_i,
  input  logic               pk_mode_i,
  output logic               mode_o,
  output logic               start_o,
  output xfer_t              xfer_o,
  input  logic               done_i,
  output logic               busy_o,
  output logic               conv_reset_o,
  output logic               conv_mute_o,
  output logic               conv_enable_o
);

  localparam int WW = $clog2(WAIT_CYCLES + 1);

  typedef enum logic [2:0] {C_HOLD_RST, C_HOLD_ALL, C_ISSUE, C_WAIT, C_IDLE} ctl_st_e;

  ctl_st_e            st_q, st_d;
  logic [WW-1:0]      wcnt_q, wcnt_d;
  xfer_list_t         list_q, list_d;
  logic [LIST_LW-1:0] len_q, len_d;
  logic [LIST_IW-1:0] idx_q, idx_d;
  logic               busy_q, busy_d;
  logic               mode_q, mode_d;
  logic               crst_q, crst_d;
  logic               cmute_q, cmute_d;
  logic               cen_q, cen_d;
  logic               wait_end;
  logic               last_item;

  assign wait_end  = (wcnt_q == WW'(WAIT_CYCLES - 1));
  assign last_item = (LIST_LW'(idx_q) == len_q - 1'b1);

  always_comb begin
    st_d    = st_q;
    wcnt_d  = wcnt_q;
    list_d  = list_q;
    len_d   = len_q;
    idx_d   = idx_q;
    busy_d  = busy_q;
    mode_d  = mode_q;
    crst_d  = crst_q;
    cmute_d = cmute_q;
    cen_d   = cen_q;
    case (st_q)
      C_HOLD_RST: begin
        crst_d = 1'b1;
        if (wait_end) begin
          wcnt_d  = '0;
          cmute_d = 1'b1;
          cen_d   = 1'b1;
          st_d    = C_HOLD_ALL;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      C_HOLD_ALL: begin
        if (wait_end) begin
          wcnt_d    = '0;
          list_d[0] = mk_short(OP_POWER);
          list_d[1] = mk_short(OP_SPEED_LO);
          list_d[2] = mk_short(OP_UNMUTE);
          list_d[3] = mk_short(OP_RUN);
          len_d     = LIST_LW'(4);
          idx_d     = '0;
          mode_d    = 1'b0;
          st_d      = C_ISSUE;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      C_ISSUE: begin
        busy_d = 1'b1;
        st_d   = C_WAIT;
      end
      C_WAIT: begin
        if (done_i) begin
          if (last_item) begin
            busy_d = 1'b0;
            st_d   = C_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = C_ISSUE;
          end
        end
      end
      C_IDLE: begin
        if (req_valid_i && (pk_len_i != '0)) begin
          list_d = pk_list_i;
          len_d  = pk_len_i;
          idx_d  = '0;
          mode_d = pk_mode_i;
          st_d   = C_ISSUE;
        end
      end
      default: st_d = C_HOLD_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= C_HOLD_RST;
      wcnt_q  <= '0;
      list_q  <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      mode_q  <= 1'b0;
      crst_q  <= 1'b1;
      cmute_q <= 1'b0;
      cen_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      wcnt_q  <= wcnt_d;
      list_q  <= list_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      busy_q  <= busy_d;
      mode_q  <= mode_d;
      crst_q  <= crst_d;
      cmute_q <= cmute_d;
      cen_q   <= cen_d;
    end
  end

  assign req_ready_o   = (st_q == C_IDLE);
  assign start_o       = (st_q == C_ISSUE);
  assign xfer_o        = list_q[idx_q];
  assign busy_o        = busy_q;
  assign mode_o        = mode_q;
  assign conv_reset_o  = crst_q;
  assign conv_mute_o   = cmute_q;
  assign conv_enable_o = cen_q;

  // R2: mute and enable never leave the asserted state once raised
  p_ctl_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cen_q) |-> (cen_q && cmute_q && crst_q));

  // R10: the engine only gets a new word after the previous one finished
  p_start_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == C_ISSUE && $past(st_q) == C_WAIT) |-> $past(done_i));

endmodule

// File: rtl/codec_cmd_seq.sv
module codec_cmd_seq
  import codec_seq_pkg::*;
#(
  parameter int DIV         = 4,
  parameter int WAIT_CYCLES = 625000,
  parameter int RATE_W      = 18,
  parameter int SPLIT_HZ    = 55000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_chan,
  input  logic [7:0]        req_level,
  input  logic [7:0]        req_line_l,
  input  logic [7:0]        req_line_r,
  input  logic [7:0]        req_mic,
  input  logic [RATE_W-1:0] req_rate,
  output logic              busy,
  output logic              conv_reset,
  output logic              conv_mute,
  output logic              conv_enable,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              sel_play_n,
  output logic              sel_cap_n
);

  xfer_list_t         pk_list;
  logic [LIST_LW-1:0] pk_len;
  logic               pk_mode;
  logic               cur_mode;
  logic               eng_start;
  xfer_t              eng_xfer;
  logic               eng_done;

  codec_req_pack #(
    .RATE_W   (RATE_W),
    .SPLIT_HZ (SPLIT_HZ)
  ) u_pack (
    .kind_i   (req_kind),
    .chan_i   (req_chan),
    .level_i  (req_level),
    .line_l_i (req_line_l),
    .line_r_i (req_line_r),
    .mic_i    (req_mic),
    .rate_i   (req_rate),
    .mode_i   (cur_mode),
    .list_o   (pk_list),
    .len_o    (pk_len),
    .mode_o   (pk_mode)
  );

  codec_seq_ctrl #(
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid),
    .req_ready_o   (req_ready),
    .pk_list_i     (pk_list),
    .pk_len_i      (pk_len),
    .pk_mode_i     (pk_mode),
    .mode_o        (cur_mode),
    .start_o       (eng_start),
    .xfer_o        (eng_xfer),
    .done_i        (eng_done),
    .busy_o        (busy),
    .conv_reset_o  (conv_reset),
    .conv_mute_o   (conv_mute),
    .conv_enable_o (conv_enable)
  );

  codec_shift_engine #(
    .DIV (DIV)
  ) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (eng_start),
    .xfer_i       (eng_xfer),
    .sclk_o       (ser_clk),
    .sdata_o      (ser_data),
    .sel_play_n_o (sel_play_n),
    .sel_cap_n_o  (sel_cap_n),
    .done_o       (eng_done)
  );

  // R11: a low select is always covered by busy
  p_busy_covers_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_play_n || !sel_cap_n) |-> busy);

  // R10: no acceptance while a script runs
  p_ready_low_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R2: the serial port stays quiet until the converter is enabled
  p_init_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_enable |-> (sel_play_n && sel_cap_n && !req_ready));

endmodule

// File: tb/test_codec_cmd_seq.sv
`timescale 1ns/1ps
module test_codec_cmd_seq;

  localparam int DIV  = 2;
  localparam int WAIT = 40;
  localparam int RW   = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_kind;
  logic [1:0]    req_chan;
  logic [7:0]    req_level, req_line_l, req_line_r, req_mic;
  logic [RW-1:0] req_rate;
  logic          busy, conv_reset, conv_mute, conv_enable;
  logic          ser_clk, ser_data, sel_play_n, sel_cap_n;

  codec_cmd_seq #(
    .DIV(DIV), .WAIT_CYCLES(WAIT), .RATE_W(RW), .SPLIT_HZ(55000)
  ) i_codec_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_chan(req_chan), .req_level(req_level),
    .req_line_l(req_line_l), .req_line_r(req_line_r), .req_mic(req_mic),
    .req_rate(req_rate), .busy(busy), .conv_reset(conv_reset),
    .conv_mute(conv_mute), .conv_enable(conv_enable), .ser_clk(ser_clk),
    .ser_data(ser_data), .sel_play_n(sel_play_n), .sel_cap_n(sel_cap_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial monitor, sampled away from the active edge
  logic [31:0] shreg = '0;
  int          nb = 0;
  logic [31:0] log_word [64];
  int          log_bits [64];
  bit          log_cap  [64];
  int          log_n = 0;
  logic        sclk_prev = 1'b1, selp_prev = 1'b1, selc_prev = 1'b1, busy_prev = 1'b0;
  int          ph_cnt = 0;
  int          phase_err = 0;
  int          uncovered = 0;
  int          busy_falls = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk !== sclk_prev) begin
        if ((!sel_play_n || !sel_cap_n) && (ser_clk || nb > 0) && ph_cnt != DIV) phase_err++;
        ph_cnt = 1;
      end else begin
        ph_cnt++;
      end
      if (ser_clk && !sclk_prev && (!sel_play_n || !sel_cap_n)) begin
        shreg = {shreg[30:0], ser_data};
        nb++;
      end
      if (((sel_play_n && !selp_prev) || (sel_cap_n && !selc_prev)) && nb > 0) begin
        if (log_n < 64) begin
          log_word[log_n] = shreg;
          log_bits[log_n] = nb;
          log_cap[log_n]  = !selc_prev;
          log_n++;
        end
        shreg = '0;
        nb = 0;
      end
      if ((!sel_play_n || !sel_cap_n) && !busy) uncovered++;
      if (!busy && busy_prev) busy_falls++;
    end
    sclk_prev = ser_clk;
    selp_prev = sel_play_n;
    selc_prev = sel_cap_n;
    busy_prev = busy;
  end

  task automatic chk_frame(input int i, input logic [31:0] w, input int bits, input bit cap, input string r);
    check(log_n > i, {r, " frame present"}, 32'(log_n), 32'(i + 1));
    check(log_word[i] == w, {r, " word"}, log_word[i], w);
    check(log_bits[i] == bits, {r, " bit count"}, 32'(log_bits[i]), 32'(bits));
    check(log_cap[i] == cap, {r, " select"}, 32'(log_cap[i]), 32'(cap));
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(req_ready && !busy));
    repeat (4) @(negedge clk);
  endtask

  task automatic send_req(input logic [1:0] kind, input logic [1:0] chan, input logic [7:0] lvl,
                          input logic [7:0] ll, input logic [7:0] lr, input logic [7:0] mic,
                          input logic [RW-1:0] rate, output int waited);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_chan = chan; req_level = lvl;
    req_line_l = ll; req_line_r = lr; req_mic = mic; req_rate = rate;
    waited = 0;
    while (!req_ready) begin
      @(negedge clk);
      waited++;
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic t_reset_init();
    rst_n = 1'b0;
    req_valid = 1'b0; req_kind = 2'd3; req_chan = 0; req_level = 0;
    req_line_l = 0; req_line_r = 0; req_mic = 0; req_rate = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sel_play_n && sel_cap_n && ser_clk, "R1 selects/clock idle", {sel_play_n, sel_cap_n, ser_clk}, 3'b111);
    check(!busy && !req_ready, "R1 busy/ready low", {busy, req_ready}, 2'b00);
    check(conv_reset && !conv_mute && !conv_enable, "R1 control lines", {conv_reset, conv_mute, conv_enable}, 3'b100);
    rst_n = 1'b1;
    for (int k = 1; k <= 2 * WAIT + 1; k++) begin
      @(negedge clk);
      if (k == 1 || k == WAIT - 1)
        check({conv_reset, conv_mute, conv_enable} == 3'b100, "R2 reset alone", {conv_reset, conv_mute, conv_enable}, 3'b100);
      if (k == WAIT)
        check({conv_reset, conv_mute, conv_enable} == 3'b111, "R2 all three raised", {conv_reset, conv_mute, conv_enable}, 3'b111);
      if (k == 2 * WAIT)
        check(sel_play_n && sel_cap_n, "R2 still quiet before script", {sel_play_n, sel_cap_n}, 2'b11);
      if (k == 2 * WAIT + 1)
        check(!sel_play_n, "R2 first select time", 32'(sel_play_n), 32'd0);
    end
  endtask

  task automatic t_boot();
    wait_idle();
    check(log_n == 4, "R3 power-up word count", 32'(log_n), 32'd4);
    chk_frame(0, 32'hA007, 16, 0, "R3");
    chk_frame(1, 32'hA240, 16, 0, "R3");
    chk_frame(2, 32'hA30D, 16, 0, "R3");
    chk_frame(3, 32'hA103, 16, 0, "R3");
  endtask

  task automatic t_play();
    int base, w;
    base = log_n;
    send_req(2'd0, 2'd0, 8'h5A, 0, 0, 0, 0, w);
    @(negedge clk);
    check(!req_ready, "R10 ready low after accept", 32'(req_ready), 32'd0);
    wait_idle();
    chk_frame(base, 32'hA65A, 16, 0, "R5 left");
    send_req(2'd0, 2'd1, 8'hFF, 0, 0, 0, 0, w);
    wait_idle();
    chk_frame(base + 1, 32'hA7FF, 16, 0, "R5 right");
  endtask

  task automatic t_reject();
    int base, w;
    base = log_n;
    send_req(2'd0, 2'd2, 8'h11, 0, 0, 0, 0, w);
    repeat (60) @(negedge clk);
    check(log_n == base && sel_play_n && sel_cap_n, "R6 channel 2 ignored", 32'(log_n), 32'(base));
    send_req(2'd3, 2'd0, 8'h22, 0, 0, 0, 0, w);
    repeat (60) @(negedge clk);
    check(log_n == base && req_ready, "R6 kind 3 ignored", 32'(log_n), 32'(base));
  endtask

  task automatic t_capture();
    int base, w;
    base = log_n;
    send_req(2'd1, 2'd0, 0, 8'h07, 8'h81, 8'h3C, 0, w);
    wait_idle();
    chk_frame(base, 32'h3C3C8107, 32, 1, "R7");
  endtask

  task automatic t_rate(input logic [RW-1:0] rate, input bit expect_speed, input logic [15:0] speed_op, input string tag);
    int base, bf, w, n;
    base = log_n;
    bf = busy_falls;
    send_req(2'd2, 2'd0, 0, 0, 0, 0, rate, w);
    wait_idle();
    n = expect_speed ? 3 : 2;
    check(log_n - base == n, {tag, " R9 word count"}, 32'(log_n - base), 32'(n));
    chk_frame(base, 32'hA38D, 16, 0, {tag, " R8 mute first"});
    if (expect_speed) chk_frame(base + 1, {16'h0, speed_op}, 16, 0, {tag, " R9 speed word"});
    chk_frame(base + n - 1, 32'hA30D, 16, 0, {tag, " R8 unmute last"});
    check(busy_falls - bf == 1, {tag, " R11 one busy fall"}, 32'(busy_falls - bf), 32'd1);
  endtask

  task automatic t_holdoff();
    int base, w1, w2;
    base = log_n;
    send_req(2'd0, 2'd1, 8'h10, 0, 0, 0, 0, w1);
    send_req(2'd1, 2'd0, 0, 8'hAA, 8'hBB, 8'hCC, 0, w2);
    check(w2 > 20, "R10 second request held off", 32'(w2), 32'd21);
    wait_idle();
    chk_frame(base, 32'hA710, 16, 0, "R10 first kept");
    chk_frame(base + 1, 32'hCCCCBBAA, 32, 1, "R10 second kept");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    t_reset_init();
    t_boot();
    t_play();
    t_reject();
    t_capture();
    t_rate(18'd48000, 1'b0, 16'h0000, "48k");
    t_rate(18'd96000, 1'b1, 16'hA24D, "96k");
    t_rate(18'd55000, 1'b0, 16'h0000, "55k boundary");
    t_rate(18'd54999, 1'b1, 16'hA240, "54999");
    t_holdoff();
    check(phase_err == 0, "R4 phase length", 32'(phase_err), 32'd0);
    check(uncovered == 0, "R11 select without busy", 32'(uncovered), 32'd0);
    summary();
  end

endmodule